// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a NOR flash device. It watches host write cycles, made up of an active-low chip enable, an active-low write enable, an address and a 16-bit data word, and reads the low byte of each write as an opcode. Some commands take effect in a single write. Others take two writes, and in those the meaning of the second code depends on the first. The block also keeps a persistent read mode, which tells the read path whether a host read returns array contents, identification codes, query data or the status register.

When a command is accepted, the block sends a one-cycle strobe to the memory back end. There are strobes for program, block erase, suspend, resume, lock, unlock, lock-down and protection-area program. Each strobe comes with an operation address and a data word. The top level also contains a behavioural back-end stub. It holds a busy countdown after each operation, and it feeds the ready bit and the suspended bit of the status register. Two things are out of scope: the array itself and the analog timing.

A host write completes when the OR of the two enables rises. Address and data are captured from the synchronously sampled pins at that moment, so whichever enable goes high first decides what is latched.

Top module: `fci_top`

## Requirements
- R1: After reset the read mode is array (code 0), the status register reads 80h, and no operation strobe is active.
- R2: A single write of FFh, 90h, 98h or 70h sets the read mode to array (0), identification (1), query (2) or status (3) respectively, and the mode persists. An unrecognised opcode leaves the mode unchanged and raises no strobe.
- R3: A program setup write of 40h or 10h followed by any write raises the program strobe (op_stb bit 0), with the second write's address and data, and switches the read mode to status. The setup write alone raises no strobe.
- R4: 20h followed by D0h raises the erase strobe (bit 1), with the first write's address as the target.
- R5: 60h followed by 01h, D0h or 2Fh raises the lock (bit 4), unlock (bit 5) or lock-down (bit 6) strobe respectively, with the first write's address.
- R6: C0h followed by any write raises the protection-program strobe (bit 7), with the second write's address and data.
- R7: Any other second code after 20h or 60h raises no strobe, sets status bits 5 and 4, and sets the read mode to status.
- R8: A single write of 50h clears status bits 5 and 4.
- R9: Status bit 7 reads 0 while the back end is busy after an operation, and returns to 1 exactly BUSY_CYCLES cycles after it starts.
- R10: B0h raises the suspend strobe (bit 2). While suspended, status bit 6 is 1, bit 7 is 1 and the countdown is frozen. A standalone D0h raises the resume strobe (bit 3), clears bit 6 and restarts the countdown.
- R11: Address and data are captured when the first of the two enables rises. Changes made before the second enable rises are ignored.
- R12: At most one strobe bit is active in any cycle, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | ADDR_W | Host address |
| wdata | input | DATA_W | Host write data |
| rd_mode | output | 2 | Current read mode: 0 array, 1 ident, 2 query, 3 status |
| status | output | 8 | Status: 7 ready, 6 suspended, 5 erase/seq error, 4 program/seq error |
| op_stb | output | 8 | One-cycle operation strobes |
| op_addr | output | ADDR_W | Address accompanying a strobe |
| op_data | output | DATA_W | Data accompanying a strobe |
| busy | output | 1 | Back-end stub busy |

## Verification
The hardest state to reach from the ports is a suspended operation whose countdown is frozen partway through. Reaching it needs a program command to start, followed by a suspend write that lands while the countdown is still running. The bench therefore uses a long busy window, issues the suspend two cycles after the program strobe, holds the suspension for ten idle cycles, and then resumes. It checks that the ready bit drops again and that it returns only after the remaining count has run out.

// File: rtl/fci_pkg.sv
package fci_pkg;
   localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
   localparam logic [7:0] OP_READ_IDENT = 8'h90;
   localparam logic [7:0] OP_READ_QUERY = 8'h98;
   localparam logic [7:0] OP_READ_STAT  = 8'h70;
   localparam logic [7:0] OP_CLR_STAT   = 8'h50;
   localparam logic [7:0] OP_PGM        = 8'h40;
   localparam logic [7:0] OP_PGM_ALT    = 8'h10;
   localparam logic [7:0] OP_ERASE      = 8'h20;
   localparam logic [7:0] OP_CONFIRM    = 8'hD0;
   localparam logic [7:0] OP_SUSPEND    = 8'hB0;
   localparam logic [7:0] OP_LOCK_SETUP = 8'h60;
   localparam logic [7:0] OP_LOCK       = 8'h01;
   localparam logic [7:0] OP_LOCK_DOWN  = 8'h2F;
   localparam logic [7:0] OP_PROT       = 8'hC0;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_IDENT  = 2'd1,
      RM_QUERY  = 2'd2,
      RM_STATUS = 2'd3
   } rmode_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PGM, ST_ERASE, ST_LOCK, ST_PROT
   } dstate_t;

   localparam int STB_PGM    = 0;
   localparam int STB_ERASE  = 1;
   localparam int STB_SUSP   = 2;
   localparam int STB_RESUME = 3;
   localparam int STB_LOCK   = 4;
   localparam int STB_UNLOCK = 5;
   localparam int STB_LKDN   = 6;
   localparam int STB_PROT   = 7;
   localparam int NUM_STB    = 8;
   localparam logic [NUM_STB-1:0] STB_START_MASK = 8'b1111_0011;
endpackage

// File: rtl/fci_wr_capture.sv
module fci_wr_capture #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              wr_v,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   logic strobe_hi;
   logic strobe_q;
   logic rise;

   assign strobe_hi = ce_n | we_n;
   assign rise      = strobe_hi & ~strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b1;
         wr_v     <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         strobe_q <= strobe_hi;
         wr_v     <= rise;
         if (rise) begin
            wr_addr <= addr;
            wr_data <= wdata;
         end
      end
   end

   AST_ONE_CYCLE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_v |=> !wr_v) else $error("write pulse longer than one cycle"); // R11
endmodule

// File: rtl/fci_decoder.sv
module fci_decoder
   import fci_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int DATA_W         = 16,
   parameter bit ACCEPT_ALT_PGM = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_v,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [1:0]         rd_mode,
   output logic [NUM_STB-1:0] op_stb,
   output logic [ADDR_W-1:0]  op_addr,
   output logic [DATA_W-1:0]  op_data,
   output logic               seq_err,
   output logic               clr_err
);
   logic [7:0]        opc;
   logic              is_pgm;
   dstate_t           state;
   logic [ADDR_W-1:0] first_addr;

   assign opc = wr_data[7:0];

   generate
      if (ACCEPT_ALT_PGM) begin : g_pgm_two
         assign is_pgm = (opc == OP_PGM) || (opc == OP_PGM_ALT);
      end else begin : g_pgm_one
         assign is_pgm = (opc == OP_PGM);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         rd_mode    <= RM_ARRAY;
         op_stb     <= '0;
         op_addr    <= '0;
         op_data    <= '0;
         seq_err    <= 1'b0;
         clr_err    <= 1'b0;
         first_addr <= '0;
      end else begin
         op_stb  <= '0;
         seq_err <= 1'b0;
         clr_err <= 1'b0;
         if (wr_v) begin
            case (state)
               ST_IDLE: begin
                  first_addr <= wr_addr;
                  if (is_pgm) begin
                     state <= ST_PGM;
                  end else begin
                     case (opc)
                        OP_READ_ARRAY: rd_mode <= RM_ARRAY;
                        OP_READ_IDENT: rd_mode <= RM_IDENT;
                        OP_READ_QUERY: rd_mode <= RM_QUERY;
                        OP_READ_STAT:  rd_mode <= RM_STATUS;
                        OP_CLR_STAT:   clr_err <= 1'b1;
                        OP_ERASE:      state   <= ST_ERASE;
                        OP_LOCK_SETUP: state   <= ST_LOCK;
                        OP_PROT:       state   <= ST_PROT;
                        OP_SUSPEND: begin
                           op_stb[STB_SUSP] <= 1'b1;
                           op_addr          <= wr_addr;
                           op_data          <= wr_data;
                           rd_mode          <= RM_STATUS;
                        end
                        OP_CONFIRM: begin
                           op_stb[STB_RESUME] <= 1'b1;
                           op_addr            <= wr_addr;
                           op_data            <= wr_data;
                           rd_mode            <= RM_STATUS;
                        end
                        default: ;
                     endcase
                  end
               end
               ST_PGM, ST_PROT: begin
                  op_stb[(state == ST_PGM) ? STB_PGM : STB_PROT] <= 1'b1;
                  op_addr <= wr_addr;
                  op_data <= wr_data;
                  rd_mode <= RM_STATUS;
                  state   <= ST_IDLE;
               end
               ST_ERASE: begin
                  rd_mode <= RM_STATUS;
                  state   <= ST_IDLE;
                  op_addr <= first_addr;
                  op_data <= wr_data;
                  if (opc == OP_CONFIRM) op_stb[STB_ERASE] <= 1'b1;
                  else                   seq_err <= 1'b1;
               end
               ST_LOCK: begin
                  rd_mode <= RM_STATUS;
                  state   <= ST_IDLE;
                  op_addr <= first_addr;
                  op_data <= wr_data;
                  case (opc)
                     OP_LOCK:      op_stb[STB_LOCK]   <= 1'b1;
                     OP_CONFIRM:   op_stb[STB_UNLOCK] <= 1'b1;
                     OP_LOCK_DOWN: op_stb[STB_LKDN]   <= 1'b1;
                     default:      seq_err <= 1'b1;
                  endcase
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(op_stb)) else $error("several strobes at once"); // R12
   AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (|op_stb) |-> $past(wr_v)) else $error("strobe without write"); // R12
   AST_MODE_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (|(op_stb & STB_START_MASK)) |-> (rd_mode == RM_STATUS))
      else $error("mode not status after op"); // R3
   AST_ERR_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> (op_stb == '0)) else $error("strobe on bad sequence"); // R7
endmodule

// File: rtl/fci_status.sv
module fci_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       seq_err,
   input  logic       clr_err,
   input  logic       busy,
   input  logic       susp,
   output logic [7:0] status
);
   logic [1:0] err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 2'b00;
      else if (seq_err) err_q <= 2'b11;
      else if (clr_err) err_q <= 2'b00;
   end

   assign status = {~busy, susp, err_q, 4'b0000};

   AST_ERR_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q[1]) |-> $past(seq_err)) else $error("error without cause"); // R7
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr_err) && !$past(seq_err)) |-> (err_q == 2'b00))
      else $error("error not cleared"); // R8
endmodule

// File: rtl/fci_backend_stub.sv
module fci_backend_stub
   import fci_pkg::*;
#(
   parameter int BUSY_CYCLES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_STB-1:0] op_stb,
   output logic               busy,
   output logic               susp
);
   localparam int CW = $clog2(BUSY_CYCLES + 1);
   logic [CW-1:0] cnt;
   logic          start;

   assign start = (|(op_stb & STB_START_MASK)) && (cnt == '0);
   assign busy  = (cnt != '0) && !susp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         susp <= 1'b0;
      end else begin
         if (start)                    cnt <= CW'(BUSY_CYCLES);
         else if (cnt != '0 && !susp)  cnt <= cnt - 1'b1;
         if (op_stb[STB_SUSP] && cnt != '0) susp <= 1'b1;
         else if (op_stb[STB_RESUME])       susp <= 1'b0;
      end
   end

   AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(susp) && susp) |-> (cnt == $past(cnt)))
      else $error("count moved while suspended"); // R10
endmodule

// File: rtl/fci_top.sv
module fci_top
   import fci_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int DATA_W         = 16,
   parameter int BUSY_CYCLES    = 16,
   parameter bit ACCEPT_ALT_PGM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [1:0]        rd_mode,
   output logic [7:0]        status,
   output logic [7:0]        op_stb,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              busy
);
   generate
      if (ADDR_W < 2)       begin : g_bad_addr  $error("ADDR_W too small"); end
      if (DATA_W < 8)       begin : g_bad_data  $error("DATA_W below opcode width"); end
      if (BUSY_CYCLES < 1)  begin : g_bad_busy  $error("BUSY_CYCLES must be positive"); end
   endgenerate

   logic              wr_v, seq_err, clr_err, susp;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   fci_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
      .wdata(wdata), .wr_v(wr_v), .wr_addr(wr_addr), .wr_data(wr_data));

   fci_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .ACCEPT_ALT_PGM(ACCEPT_ALT_PGM)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_v(wr_v), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_mode(rd_mode), .op_stb(op_stb),
      .op_addr(op_addr), .op_data(op_data), .seq_err(seq_err),
      .clr_err(clr_err));

   fci_backend_stub #(.BUSY_CYCLES(BUSY_CYCLES)) u_stub (
      .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .busy(busy), .susp(susp));

   fci_status u_stat (
      .clk(clk), .rst_n(rst_n), .seq_err(seq_err), .clr_err(clr_err),
      .busy(busy), .susp(susp), .status(status));
endmodule

// File: tb/fci_top_bench.sv
module fci_top_bench;
   localparam int AW = 20;
   localparam int DW = 16;
   localparam int BC = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [1:0]    rd_mode;
   logic [7:0]    status;
   logic [7:0]    op_stb;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;
   logic          busy;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fci_top #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BC)) u_fci_top (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
      .wdata(wdata), .rd_mode(rd_mode), .status(status), .op_stb(op_stb),
      .op_addr(op_addr), .op_data(op_data), .busy(busy));

   // {opcode, expected read mode}
   localparam logic [9:0] VEC [0:6] = '{
      {8'h90, 2'd1}, {8'h98, 2'd2}, {8'h33, 2'd2}, {8'h70, 2'd3},
      {8'hFF, 2'd0}, {8'h98, 2'd2}, {8'hFF, 2'd0}};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Full write cycle; returns at the negedge where decoder outputs are valid.
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1; addr = '1; wdata = 16'hEEEE;
      @(negedge clk);
   endtask

   task automatic wait_ready(input string req);
      int k = 0;
      while (status[7] !== 1'b1 && k < 100) begin
         @(negedge clk);
         k++;
      end
      chk(status[7] === 1'b1, req, status, 8'h80);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rd_mode == 2'd0, "R1 mode", rd_mode, 0);
      chk(status == 8'h80, "R1 status", status, 8'h80);
      chk(op_stb == 8'h00, "R1 strobes", op_stb, 0);

      // R2 table of read-mode commands
      for (int i = 0; i < 7; i++) begin
         wr(20'h00010, {8'h00, VEC[i][9:2]});
         chk(rd_mode == VEC[i][1:0], "R2 mode", rd_mode, VEC[i][1:0]);
         chk(op_stb == 8'h00, "R2 no strobe", op_stb, 0);
      end

      // R3 program with 40h, R9 busy timing
      wr(20'h00100, 16'h0040);
      chk(op_stb == 8'h00, "R3 setup no strobe", op_stb, 0);
      wr(20'h00155, 16'h1234);
      chk(op_stb == 8'h01, "R3 pgm strobe", op_stb, 1);
      chk(op_addr == 20'h00155, "R3 pgm addr", op_addr, 20'h155);
      chk(op_data == 16'h1234, "R3 pgm data", op_data, 16'h1234);
      chk(rd_mode == 2'd3, "R3 mode status", rd_mode, 3);
      @(negedge clk);
      chk(op_stb == 8'h00, "R12 strobe one cycle", op_stb, 0);
      chk(status[7] == 1'b0, "R9 busy start", status, 0);
      repeat (BC - 1) @(negedge clk);
      chk(status[7] == 1'b0, "R9 still busy", status, 0);
      @(negedge clk);
      chk(status == 8'h80, "R9 ready after count", status, 8'h80);

      // R3 alternate setup code
      wr(20'h00200, 16'h0010);
      wr(20'h00201, 16'hBEEF);
      chk(op_stb == 8'h01 && op_data == 16'hBEEF, "R3 alt pgm", op_stb, 1);
      wait_ready("R9 ready");

      // R4 erase uses first address
      wr(20'h03000, 16'h0020);
      wr(20'h03ABC, 16'h00D0);
      chk(op_stb == 8'h02, "R4 erase strobe", op_stb, 2);
      chk(op_addr == 20'h03000, "R4 erase addr", op_addr, 20'h3000);
      wait_ready("R9 ready");

      // R5 lock variants
      wr(20'h01234, 16'h0060); wr(20'h09999, 16'h0001);
      chk(op_stb == 8'h10 && op_addr == 20'h01234, "R5 lock", op_stb, 8'h10);
      wait_ready("R9 ready");
      wr(20'h05678, 16'h0060); wr(20'h0AAAA, 16'h00D0);
      chk(op_stb == 8'h20 && op_addr == 20'h05678, "R5 unlock", op_stb, 8'h20);
      wait_ready("R9 ready");
      wr(20'h04321, 16'h0060); wr(20'h0BBBB, 16'h002F);
      chk(op_stb == 8'h40 && op_addr == 20'h04321, "R5 lockdown", op_stb, 8'h40);
      wait_ready("R9 ready");

      // R6 protection program
      wr(20'h00081, 16'h00C0); wr(20'h00082, 16'hABCD);
      chk(op_stb == 8'h80, "R6 prot strobe", op_stb, 8'h80);
      chk(op_addr == 20'h00082 && op_data == 16'hABCD, "R6 prot addr/data", op_data, 16'hABCD);
      wait_ready("R9 ready");

      // R7 / R8 bad confirm codes
      wr(20'h0, 16'h00FF);
      wr(20'h03000, 16'h0020); wr(20'h03000, 16'h0055);
      chk(op_stb == 8'h00, "R7 no strobe", op_stb, 0);
      chk(rd_mode == 2'd3, "R7 mode status", rd_mode, 3);
      @(negedge clk);
      chk(status == 8'hB0, "R7 error bits", status, 8'hB0);
      wr(20'h0, 16'h0050);
      @(negedge clk);
      chk(status == 8'h80, "R8 clear", status, 8'h80);
      wr(20'h0, 16'h0060); wr(20'h0, 16'h0077);
      chk(op_stb == 8'h00, "R7 lock bad no strobe", op_stb, 0);
      @(negedge clk);
      chk(status == 8'hB0, "R7 lock bad error", status, 8'hB0);
      wr(20'h0, 16'h0050);
      @(negedge clk);
      chk(status == 8'h80, "R8 clear again", status, 8'h80);

      // R10 suspend / resume
      wr(20'h00300, 16'h0040); wr(20'h00300, 16'h5A5A);
      repeat (2) @(negedge clk);
      wr(20'h00300, 16'h00B0);
      chk(op_stb == 8'h04, "R10 suspend strobe", op_stb, 4);
      @(negedge clk);
      chk(status == 8'hC0, "R10 suspended status", status, 8'hC0);
      repeat (10) @(negedge clk);
      chk(status == 8'hC0, "R10 held suspended", status, 8'hC0);
      wr(20'h00300, 16'h00D0);
      chk(op_stb == 8'h08, "R10 resume strobe", op_stb, 8);
      @(negedge clk);
      chk(status == 8'h00, "R10 busy after resume", status, 0);
      wait_ready("R10 ready after resume");

      // R11 chip enable rises first; later data change ignored
      wr(20'h0, 16'h00FF);
      ce_n = 1'b0; we_n = 1'b0; wdata = 16'h0090;
      @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      wdata = 16'h0098;
      @(negedge clk);
      we_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(rd_mode == 2'd1, "R11 first rise capture", rd_mode, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule